// File: doc/BRIEF.md
# Buffered Compare Channel with Batch Reload

This block is one compare channel of a general-purpose timer, with its own time base. A 16-bit up-counter runs while the enable input is high and returns to zero after it reaches a programmable period value. Software writes a new compare value into a holding buffer through a simple write strobe. The active compare register is what the counter is compared against. It takes the buffered value at a point chosen by a mode input.

With the mode input high (anytime mode), a buffer write reaches the active register on the next clock. With the mode input low (batch mode), a buffer write arms an internal pending flag. The buffer is then copied into the active register only at the next transfer point, which is the clock edge at which the counter goes from the period value back to zero. The pending flag clears after a transfer. Raising the mode input also clears the flag at once. Lowering the mode input again does not re-arm it, so a cancelled update is dropped until the next batch-mode write. The mode input may change while the counter runs.

The match output is high in every cycle in which the timer is enabled and the counter equals the active compare value.

Top module: `cmp_reload_chan`

## Requirements
- R1: After reset, cnt_o is 0x0000, cmp_o is 0x0000, match_o is 0 and no transfer is pending.
- R2: While en_i is 1, cnt_o increments by one per clock, and after a cycle in which it equals period_i it becomes 0x0000. While en_i is 0, cnt_o holds its value.
- R3: With mode_i = 1, a write (wr_en_i = 1) puts wr_data_i into cmp_o at the next clock edge.
- R4: With mode_i = 0, a write leaves cmp_o unchanged until the transfer point (the edge at which cnt_o goes from period_i to 0). At that edge cmp_o takes the buffered value.
- R5: Holding mode_i = 1 for at least one clock cancels a pending transfer. After mode_i returns to 0, later transfer points leave cmp_o unchanged until a new write is made with mode_i = 0.
- R6: A write with mode_i = 0 in the same cycle as a transfer point is transferred at that edge.
- R7: match_o is 1 exactly in the cycles where en_i = 1 and cnt_o equals cmp_o, and is 0 whenever en_i = 0.
- R8: With several writes made in batch mode before one transfer point, the last value written is the one transferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| period_i | input | 16 | Last count value before wrap |
| mode_i | input | 1 | 1 = anytime update, 0 = batch update |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 16 | Buffer write data |
| cnt_o | output | 16 | Counter value |
| cmp_o | output | 16 | Active compare value |
| match_o | output | 1 | Counter equals active compare while enabled |

## Verification
An anytime-mode write is due on cmp_o one clock edge after the strobe. A batch-mode write shows only at the edge where cnt_o wraps from period_i to zero. match_o is combinational from registered state, so it is due in the same cycle as the counter value. The bench drives every input just after a falling edge and samples just before the next falling edge, so each rising edge between the two is counted exactly. The batch tests step the counter with wait loops to a known count before they write, so the transfer edge falls at a known place.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int CNT_W_DEF = 16;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_BUS  = 2'd1,
    LD_BUF  = 2'd2
  } load_sel_e;
endpackage

// File: rtl/cmp_counter.sv
module cmp_counter #(
  parameter int W = cmp_pkg::CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == period_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
  parameter int W = cmp_pkg::CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         wrap_i,
  output logic [W-1:0] cmp_o,
  output logic         req_o
);
  import cmp_pkg::*;

  logic [W-1:0] buf_q, cmp_q;
  logic         req_q, req_d;
  load_sel_e    sel;

  // load source for the active register
  always_comb begin
    sel = LD_NONE;
    if (mode_i) begin
      if (wr_en_i) sel = LD_BUS;
    end else if (wrap_i) begin
      if (wr_en_i)    sel = LD_BUS;
      else if (req_q) sel = LD_BUF;
    end
  end

  always_comb begin
    req_d = req_q;
    if (mode_i)       req_d = 1'b0;
    else if (wrap_i)  req_d = 1'b0;
    else if (wr_en_i) req_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cmp_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (wr_en_i) buf_q <= wr_data_i;
      case (sel)
        LD_BUS:  cmp_q <= wr_data_i;
        LD_BUF:  cmp_q <= buf_q;
        default: cmp_q <= cmp_q;
      endcase
    end
  end

  assign cmp_o = cmp_q;
  assign req_o = req_q;
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int W = cmp_pkg::CNT_W_DEF
) (
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         match_o
);
  assign match_o = en_i && (cnt_i == cmp_i);
endmodule

// File: rtl/cmp_reload_chan.sv
module cmp_reload_chan #(
  parameter int W = cmp_pkg::CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic         mode_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         match_o
);
  logic wrap_w;
  logic req_w;

  cmp_counter #(.W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .period_i(period_i),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap_w)
  );

  cmp_shadow #(.W(W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wrap_i   (wrap_w),
    .cmp_o    (cmp_o),
    .req_o    (req_w)
  );

  cmp_match #(.W(W)) u_match (
    .en_i   (en_i),
    .cnt_i  (cnt_o),
    .cmp_i  (cmp_o),
    .match_o(match_o)
  );
endmodule

// File: rtl/cmp_reload_chan_chk.sv
module cmp_reload_chan_chk #(
  parameter int W = cmp_pkg::CNT_W_DEF
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [W-1:0] period_i,
  input logic         mode_i,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] cmp_o,
  input logic         req_i
);
  localparam logic [W-1:0] ONE = W'(1);
  logic at_wrap;
  assign at_wrap = en_i && (cnt_o == period_i);

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_wrap |=> cnt_o == '0); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !at_wrap) |=> cnt_o == $past(cnt_o) + ONE); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o)); // R2
  AST_ANY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && wr_en_i) |=> cmp_o == $past(wr_data_i)); // R3
  AST_BATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !at_wrap) |=> $stable(cmp_o)); // R4
  AST_REQ_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && wr_en_i && !at_wrap) |=> req_i); // R4
  AST_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> !req_i); // R5
  AST_SAME_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && wr_en_i && at_wrap) |=> (cmp_o == $past(wr_data_i)) && !req_i); // R6
endmodule

bind cmp_reload_chan cmp_reload_chan_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .period_i (period_i),
  .mode_i   (mode_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .cnt_o    (cnt_o),
  .cmp_o    (cmp_o),
  .req_i    (req_w)
);

// File: tb/cmp_reload_chan_test.sv
module cmp_reload_chan_test;
  localparam int W = 16;
  localparam logic [W-1:0] PER = 16'd5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] period_i = PER;
  logic         mode_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] cnt_o, cmp_o;
  logic         match_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_reload_chan #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
    .mode_i(mode_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cnt_o(cnt_o), .cmp_o(cmp_o), .match_o(match_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cnt(logic [W-1:0] v);
    for (int i = 0; i < 64; i++) begin
      if (cnt_o == v) return;
      step();
    end
  endtask

  task automatic wr_pulse(logic [W-1:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_o, '0);
    chk("R1 cmp", cmp_o, '0);
    chk("R1 match", W'(match_o), '0);
    // no pending transfer: a wrap in batch mode with a written-but-unarmed buffer is not needed;
    // a wrap must leave cmp_o at zero
    en_i = 1'b1;
    wait_cnt(PER);
    step();
    chk("R1 no pending", cmp_o, '0);
    en_i = 1'b0;
  endtask

  task automatic t_count();
    logic [W-1:0] exp;
    en_i = 1'b1;
    exp = cnt_o;
    for (int i = 0; i < 8; i++) begin
      exp = (exp == PER) ? '0 : exp + 1'b1;
      step();
      chk("R2 count", cnt_o, exp);
    end
    en_i = 1'b0;
    exp = cnt_o;
    repeat (3) step();
    chk("R2 hold", cnt_o, exp);
    en_i = 1'b1;
  endtask

  task automatic t_anytime();
    mode_i = 1'b1;
    wr_pulse(16'h0003);
    chk("R3 anytime", cmp_o, 16'h0003);
  endtask

  task automatic t_batch();
    mode_i = 1'b0;
    wait_cnt(16'd1);
    wr_pulse(16'h0004);
    chk("R4 hold before wrap", cmp_o, 16'h0003);
    wr_pulse(16'h0001);
    chk("R4 hold second write", cmp_o, 16'h0003);
    wait_cnt(PER);
    chk("R4 hold at period", cmp_o, 16'h0003);
    step();
    chk("R4 wrap count", cnt_o, '0);
    chk("R8 last write wins", cmp_o, 16'h0001);
  endtask

  task automatic t_cancel();
    wait_cnt(16'd1);
    wr_pulse(16'h0002);
    mode_i = 1'b1;
    step();
    mode_i = 1'b0;
    wait_cnt(PER);
    step();
    chk("R5 cancelled wrap 1", cmp_o, 16'h0001);
    wait_cnt(PER);
    step();
    chk("R5 cancelled wrap 2", cmp_o, 16'h0001);
  endtask

  task automatic t_same_edge();
    wait_cnt(PER);
    wr_pulse(16'h0003);
    chk("R6 wrap count", cnt_o, '0);
    chk("R6 same-edge load", cmp_o, 16'h0003);
  endtask

  task automatic t_match();
    for (int i = 0; i < 12; i++) begin
      step();
      chk("R7 match", W'(match_o), W'(cnt_o == cmp_o));
    end
    wait_cnt(16'h0003);
    en_i = 1'b0;
    #1;
    chk("R7 disabled", W'(match_o), '0);
    step();
    chk("R7 disabled hold", W'(match_o), '0);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_count();
    t_anytime();
    t_batch();
    t_cancel();
    t_same_edge();
    t_match();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule